// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block connects a clocked host to an external asynchronous 8K x 8 static RAM. The host makes a request by raising a valid strobe for one cycle, together with a read/write flag, an address and, for a write, a data byte. The controller registers these inputs. It then generates the chip-select, write-strobe, output-enable and data-bus sequence the RAM expects, counted in whole clock cycles. For a read it holds the address and the read enable for a programmable number of access cycles. It then captures the byte and presents it with a one-cycle valid pulse.

The RAM is selected by a pair of chip enables of opposite polarity. Its write strobe and output enable are both active low. Its data bus is shared in both directions and is modelled here as separate outgoing data, outgoing-enable and incoming data ports. The controller keeps its driver off whenever the RAM may be driving. The RAM captures a write on the rising edge of the write strobe, so the controller keeps the address and data steady on both sides of that edge. A busy flag tells the host when the controller can take a new request.

Top module: `sram_bus_ctrl`

## Requirements
- R1: A synchronous active-high reset sets memCe1N=1, memCe2=0, memWeN=1, memOeN=1, memDoutEn=0, busy=0 and rdValid=0, and these values are seen in the cycle that follows the reset edge.
- R2: The RAM counts as selected only when memCe1N=0 and memCe2=1 together. memWeN=0 and memOeN=0 each occur only while the RAM is selected.
- R3: A read accepted at clock edge E0 keeps the RAM selected, with memOeN=0 and the request address on memAddr, for RD_WAIT cycles. memDin is sampled at edge E0+RD_WAIT. The sampled byte appears on rdData with rdValid=1 in the cycle after that edge.
- R4: A write accepted at edge E0 runs in this order. First comes one setup cycle with the RAM selected, memWeN=1 and the data driven. Next, memWeN=0 for WR_PULSE cycles with the data driven. Then comes one hold cycle with memWeN=1 and the RAM still selected, in which address and data are unchanged. The RAM and the bus are then released.
- R5: memAddr does not change while memWeN=0, and the write data on memDout is stable across the rising edge of memWeN.
- R6: memDoutEn is never 1 while the RAM is selected with memOeN=0. After a read, the RAM stays deselected for TURN_CYC cycles before the controller can accept the next request. So the bus is driven only more than TURN_CYC cycles after the output enable was last low.
- R7: busy is 1 from the cycle after acceptance until the transaction completes: RD_WAIT+TURN_CYC cycles for a read and WR_PULSE+2 cycles for a write. A request is accepted at any edge where busy=0 and reqValid=1.
- R8: A request presented while busy=1 is ignored. It starts no transaction and writes nothing. If reqValid stays high, the request is accepted at the first edge where busy=0.
- R9: rdValid is high for exactly one clock per accepted read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Host request strobe |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | DATA_W | Write data |
| busy | output | 1 | Transaction in progress, requests ignored |
| rdValid | output | 1 | One-cycle read-data strobe |
| rdData | output | DATA_W | Captured read byte |
| memAddr | output | ADDR_W | RAM address |
| memCe1N | output | 1 | RAM chip enable, active low |
| memCe2 | output | 1 | RAM chip enable, active high |
| memWeN | output | 1 | RAM write strobe, active low |
| memOeN | output | 1 | RAM output enable, active low |
| memDout | output | DATA_W | Data toward the RAM |
| memDoutEn | output | 1 | Enable of the controller's bus driver |
| memDin | input | DATA_W | Data from the RAM |

## Verification
A new host request and the completion of the running transaction can fall in the same cycle. A request pulsed during a write must leave the RAM unchanged. A request held high across the last busy cycle must be taken on the first idle edge, with busy low for exactly one cycle. The bench holds reqValid high across a write's completion and counts the idle cycles. It also pulses a conflicting write in mid-transaction and later reads back the address. A second collision lies between the end of a read's turnaround and the first driven cycle of a following write. A bus model measures the output-enable age whenever the controller drives.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_TURN,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD
  } ctrl_state_e;

  // strobes from control to datapath, decoded from the next state
  typedef struct packed {
    logic load;     // capture host request
    logic chipOn;   // select the RAM
    logic readOn;   // output enable low
    logic writeOn;  // write strobe low
    logic driveOn;  // drive the data bus
    logic sample;   // capture read data
  } ctrl_strobe_t;

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_WAIT  = 3,
  parameter int WR_PULSE = 2,
  parameter int TURN_CYC = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reqValid,
  input  logic         reqWrite,
  output ctrl_strobe_t strobe,
  output logic         busy
);

  localparam int MAX_A = (RD_WAIT > WR_PULSE) ? RD_WAIT : WR_PULSE;
  localparam int MAX_C = (MAX_A > TURN_CYC) ? MAX_A : TURN_CYC;
  localparam int CNT_W = (MAX_C > 1) ? $clog2(MAX_C) : 1;

  ctrl_state_e state, nextState;
  logic [CNT_W-1:0] cnt, cntNext;
  logic takeReq, sampleNow;

  always_comb begin
    nextState = state;
    cntNext   = cnt;
    takeReq   = 1'b0;
    sampleNow = 1'b0;
    unique case (state)
      ST_IDLE: begin
        cntNext = '0;
        if (reqValid) begin
          takeReq   = 1'b1;
          nextState = reqWrite ? ST_WR_SETUP : ST_RD_ACC;
        end
      end
      ST_RD_ACC: begin
        if (cnt == CNT_W'(RD_WAIT - 1)) begin
          sampleNow = 1'b1;
          cntNext   = '0;
          nextState = ST_RD_TURN;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      ST_RD_TURN: begin
        if (cnt == CNT_W'(TURN_CYC - 1)) begin
          cntNext   = '0;
          nextState = ST_IDLE;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      ST_WR_SETUP: begin
        cntNext   = '0;
        nextState = ST_WR_PULSE;
      end
      ST_WR_PULSE: begin
        if (cnt == CNT_W'(WR_PULSE - 1)) begin
          cntNext   = '0;
          nextState = ST_WR_HOLD;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      ST_WR_HOLD: nextState = ST_IDLE;
      default:    nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.load    = takeReq;
    strobe.sample  = sampleNow;
    strobe.chipOn  = (nextState == ST_RD_ACC)   || (nextState == ST_WR_SETUP) ||
                     (nextState == ST_WR_PULSE) || (nextState == ST_WR_HOLD);
    strobe.readOn  = (nextState == ST_RD_ACC);
    strobe.writeOn = (nextState == ST_WR_PULSE);
    strobe.driveOn = (nextState == ST_WR_SETUP) || (nextState == ST_WR_PULSE) ||
                     (nextState == ST_WR_HOLD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      cnt   <= cntNext;
    end
  end

  assign busy = (state != ST_IDLE);

  // R7: a transaction ends only from its last phase
  a_r7_busy_ends_in_last_phase: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(state) == ST_RD_TURN) || ($past(state) == ST_WR_HOLD));

  // R8: a request while busy does not restart the sequence
  a_r8_busy_no_restart: assert property (@(posedge clk) disable iff (rst)
    (busy && reqValid && state != ST_RD_TURN && state != ST_WR_HOLD) |=> busy);

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_strobe_t      strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDin,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      memAddr   <= '0;
      memDout   <= '0;
      memCe1N   <= 1'b1;
      memCe2    <= 1'b0;
      memWeN    <= 1'b1;
      memOeN    <= 1'b1;
      memDoutEn <= 1'b0;
      rdData    <= '0;
      rdValid   <= 1'b0;
    end else begin
      memCe1N   <= ~strobe.chipOn;
      memCe2    <= strobe.chipOn;
      memWeN    <= ~strobe.writeOn;
      memOeN    <= ~strobe.readOn;
      memDoutEn <= strobe.driveOn;
      rdValid   <= strobe.sample;
      if (strobe.sample) rdData <= memDin;
      if (strobe.load) begin
        memAddr <= reqAddr;
        memDout <= reqWdata;
      end
    end
  end

  // R1: controls inactive after reset
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (memCe1N && !memCe2 && memWeN && memOeN && !memDoutEn && !rdValid));

  // R2: strobes only while selected
  a_r2_we_selected: assert property (@(posedge clk) disable iff (rst)
    !memWeN |-> (!memCe1N && memCe2));
  a_r2_oe_selected: assert property (@(posedge clk) disable iff (rst)
    !memOeN |-> (!memCe1N && memCe2));

  // R5: address frozen during the strobe; data stable across its rising edge
  a_r5_addr_stable_we: assert property (@(posedge clk) disable iff (rst)
    !memWeN |-> $stable(memAddr));
  a_r5_data_at_we_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(memWeN) |-> (memDoutEn && !memCe1N && $stable(memDout) && $stable(memAddr)));

  // R6: never drive while the RAM may drive
  a_r6_no_contention: assert property (@(posedge clk) disable iff (rst)
    memDoutEn |-> memOeN);

  // R9: read strobe lasts one clock
  a_r9_rdvalid_single: assert property (@(posedge clk) disable iff (rst)
    rdValid |=> !rdValid);

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int DATA_W   = 8,
  parameter int RD_WAIT  = 3,
  parameter int WR_PULSE = 2,
  parameter int TURN_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              busy,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  input  logic [DATA_W-1:0] memDin
);

  ctrl_strobe_t strobe;

  sram_ctrl_fsm #(
    .RD_WAIT (RD_WAIT),
    .WR_PULSE(WR_PULSE),
    .TURN_CYC(TURN_CYC)
  ) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .strobe  (strobe),
    .busy    (busy)
  );

  sram_ctrl_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .memDin   (memDin),
    .memAddr  (memAddr),
    .memCe1N  (memCe1N),
    .memCe2   (memCe2),
    .memWeN   (memWeN),
    .memOeN   (memOeN),
    .memDout  (memDout),
    .memDoutEn(memDoutEn),
    .rdData   (rdData),
    .rdValid  (rdValid)
  );

endmodule

// File: tb/tb_sram_bus_ctrl.sv
`timescale 1ns/1ps
module tb_sram_bus_ctrl;

  localparam int AW = 13;
  localparam int DW = 8;
  localparam int RDW = 3;
  localparam int WRP = 2;
  localparam int TRN = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic busy, rdValid, memCe1N, memCe2, memWeN, memOeN, memDoutEn;
  logic [DW-1:0] rdData, memDout, memDin;
  logic [AW-1:0] memAddr;

  always #5 clk = ~clk;

  sram_bus_ctrl #(.ADDR_W(AW), .DATA_W(DW), .RD_WAIT(RDW), .WR_PULSE(WRP), .TURN_CYC(TRN)) dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .busy(busy), .rdValid(rdValid), .rdData(rdData),
    .memAddr(memAddr), .memCe1N(memCe1N), .memCe2(memCe2), .memWeN(memWeN),
    .memOeN(memOeN), .memDout(memDout), .memDoutEn(memDoutEn), .memDin(memDin));

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural RAM ----------------
  logic [DW-1:0] ram [int];
  logic [DW-1:0] expMem [int];
  int accCnt = 0;
  int sinceOe = 100;
  logic [AW-1:0] lastAddr = '0;
  logic prevWeN = 1'b1, prevSel = 1'b0;

  function automatic logic [DW-1:0] ramRead(input logic [AW-1:0] a);
    return ram.exists(int'(a)) ? ram[int'(a)] : '0;
  endfunction

  function automatic logic [DW-1:0] expRead(input logic [AW-1:0] a);
    return expMem.exists(int'(a)) ? expMem[int'(a)] : '0;
  endfunction

  wire sel = !memCe1N && memCe2;

  always_comb begin
    if (sel && !memOeN && memWeN)
      memDin = (accCnt >= RDW) ? ramRead(memAddr) : 'x;
    else
      memDin = 'z;
  end

  // protocol monitor and write capture, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (!memWeN && !sel) chk(1'b0, "R2 we without select", memWeN, 1);
      if (!memOeN && !sel) chk(1'b0, "R2 oe without select", memOeN, 1);
      if (memDoutEn && sel && !memOeN) chk(1'b0, "R6 bus contention", memDoutEn, 0);
      if (!memWeN && !prevWeN && memAddr != lastAddr)
        chk(1'b0, "R5 address moved in strobe", int'(memAddr), int'(lastAddr));
      if (!memOeN && sel) sinceOe = 0; else if (sinceOe < 100) sinceOe++;
      if (memDoutEn && sinceOe <= TRN) chk(1'b0, "R6 drive too soon after read", sinceOe, TRN + 1);
      if (sel && !memOeN && memAddr == lastAddr) accCnt++;
      else accCnt = (sel && !memOeN) ? 1 : 0;
      if (!prevWeN && prevSel && (memWeN || !sel)) begin
        chk(memDoutEn === 1'b1, "R5 data driven at strobe release", memDoutEn, 1);
        ram[int'(memAddr)] = memDout;
      end
    end
    prevWeN  = memWeN;
    prevSel  = sel;
    lastAddr = memAddr;
  end

  // ---------------- scoreboard ----------------
  logic [DW-1:0] expQ [$];
  logic prevRdV = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (rdValid) begin
        if (expQ.size() == 0) chk(1'b0, "R9 unexpected rdValid", 1, 0);
        else begin
          logic [DW-1:0] e;
          e = expQ.pop_front();
          chk(rdData === e, "R3 read data", int'(rdData), int'(e));
        end
        if (prevRdV) chk(1'b0, "R9 rdValid longer than one clock", 1, 0);
      end
      prevRdV = rdValid;
    end
  end

  // ---------------- driver tasks ----------------
  task automatic doWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int busyCnt, weLow;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    expMem[int'(a)] = d;
    // first cycle after acceptance: setup phase
    chk(sel && memWeN && memDoutEn && memAddr == a, "R4 setup phase", {memWeN, memDoutEn}, 2'b11);
    busyCnt = 0; weLow = 0;
    while (busy) begin
      busyCnt++;
      if (!memWeN) weLow++;
      @(negedge clk);
    end
    chk(weLow == WRP, "R4 strobe length", weLow, WRP);
    chk(busyCnt == WRP + 2, "R7 write busy length", busyCnt, WRP + 2);
    chk(!sel && !memDoutEn, "R4 release after hold", {sel, memDoutEn}, 0);
  endtask

  task automatic doRead(input logic [AW-1:0] a);
    int n, busyCnt, selCnt;
    expQ.push_back(expRead(a));
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
    n = 1; busyCnt = 0; selCnt = 0;
    while (busy) begin
      busyCnt++;
      if (sel && !memOeN && memAddr == a) selCnt++;
      if (rdValid) chk(n == RDW + 1, "R3 read latency", n, RDW + 1);
      n++;
      @(negedge clk);
    end
    chk(selCnt == RDW, "R3 access window", selCnt, RDW);
    chk(busyCnt == RDW + TRN, "R7 read busy length", busyCnt, RDW + TRN);
  endtask

  task automatic finishRun;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(memCe1N && !memCe2 && memWeN && memOeN && !memDoutEn && !busy && !rdValid,
        "R1 reset levels", {memCe1N, memCe2, memWeN, memOeN, memDoutEn, busy, rdValid}, 7'b1011000);

    doWrite(13'h0010, 8'hA5);
    doWrite(13'h1FFF, 8'h3C);
    doWrite(13'h0000, 8'h81);
    doRead(13'h0010);
    doRead(13'h1FFF);
    doRead(13'h0000);
    doRead(13'h0123);          // never written
    doWrite(13'h0123, 8'h7E);  // write right after a read (R6 turnaround)
    doRead(13'h0123);

    // R8: conflicting write pulsed while busy is ignored
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 13'h0050; reqWdata = 8'h22;
    @(negedge clk);
    reqAddr = 13'h0051; reqWdata = 8'h99;   // busy now
    @(negedge clk);
    chk(busy, "R8 busy during write", busy, 1);
    reqValid = 1'b0;
    expMem[32'h50] = 8'h22;
    while (busy) @(negedge clk);
    doRead(13'h0051);   // expected zero: ignored
    doRead(13'h0050);

    // R8/R7: request held across completion is taken at the first idle edge
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 13'h0060; reqWdata = 8'h5A;
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(busy, "R8 held request accepted after one idle cycle", busy, 1);
    reqValid = 1'b0;
    expMem[32'h60] = 8'h5A;
    while (busy) @(negedge clk);
    doRead(13'h0060);

    repeat (4) @(negedge clk);
    chk(expQ.size() == 0, "R9 all reads returned", expQ.size(), 0);
    finishRun();
  end

endmodule